// File: doc/BRIEF.md
# Non-Overlapping Pulse Pattern Generator

This block drives an 8-bit pulse port, organised as two 4-bit groups, with a sequence of step patterns. A built-in step timer paces the steps. One compare value sets the step period, and the timer counter clears when it reaches that value. A second, smaller compare value sets a margin inside each step. Software writes the next pattern into a staging register. The block moves the staged pattern to the port in a way that keeps complementary phases from ever being active at the same time.

In non-overlap mode each step has two timed events. At the period match, every driven bit that must go low goes low. At the later margin match, every driven bit that must go high goes high. The high-going bits are captured at the period match, so a staging write made before the margin match cannot disturb them. The margin match can set an interrupt flag, which tells software to stage the next pattern. Each group can instead run in overlapping mode, where it copies the staged value in one step at the period match. Software reaches the block through a plain register write bus.

Top module: `nov_pulse_gen`

## Requirements
- R1: While CTRL bit 0 (run) is 1, the counter steps by one per cycle. In the cycle where it equals PERIOD (address 0), a period event occurs and the counter becomes 0. Period events are therefore PERIOD+1 cycles apart. The counter holds while run is 0.
- R2: A margin event occurs in the cycle where a running counter equals MARGIN (address 1). With MARGIN below PERIOD, the rising update of a step appears MARGIN+1 cycles after its falling update.
- R3: In non-overlap mode, a period event clears every driven output bit whose STAGE (address 2) bit is 0. No other bit changes at that event.
- R4: In non-overlap mode, the next margin event sets every driven output bit that was 1 in the pattern captured at the period event.
- R5: A margin event sets the interrupt flag only while CTRL bit 1 is 1. The irq output shows the flag. Writing 1 to STATUS (address 6) bit 0 clears the flag. Writing 0 to that bit leaves it unchanged.
- R6: CTRL bit 2 selects non-overlap mode for bits 3:0, and CTRL bit 3 does the same for bits 7:4. A group in overlapping mode copies its whole staged value at the period event.
- R7: An output bit is driven only when its DIR (address 3) bit, its NDE (address 4) bit and its group's trigger enable are all 1. CTRL bit 4 is the trigger enable for bits 3:0, and CTRL bit 5 for bits 7:4. A bit that is not driven keeps its value.
- R8: A STAGE write made between a period event and the following margin event does not change the rising update of that step.
- R9: Synchronous active-low reset clears the outputs, the staging register, all configuration, the counter and the interrupt flag.
- R10: Staging 0x95, 0x65, 0x59, 0x56, 0x95 in turn produces an intermediate value of previous AND next at each step, followed by the next value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pulse_out | output | 8 | Pulse pattern outputs |
| irq | output | 1 | Interrupt request (margin-event flag) |

## Verification
The bench steps the port through the four-phase sequence. At each step it checks the intermediate AND value and the exact gap between the falling and rising updates. A design that raises and lowers bits in the same edge would show the next value with no intermediate step, and a design with a misplaced compare would show the wrong cycle gap. In one step the bench overwrites the staging register during the margin window. A design that does not capture the pending pattern would then rise to the overwritten value. Further tests cover mixed per-group modes, direction and enable masking, a disabled group trigger, the interrupt enable, the write-0 clear, and a reset during a run. In each case a design that ignored the setting would change bits that should hold, or would raise irq.

// File: rtl/nov_pkg.sv
`timescale 1ns/1ps
// nov_pkg: register addresses and bus geometry shared by the pulse generator.
// Assumes a 3-bit word address space; the data width is set by the top.
package nov_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_PERIOD = 3'd0,
        RA_MARGIN = 3'd1,
        RA_STAGE  = 3'd2,
        RA_DIR    = 3'd3,
        RA_NDE    = 3'd4,
        RA_CTRL   = 3'd5,
        RA_STATUS = 3'd6
    } reg_addr_e;

    // Fixed CTRL bit positions; per-group fields follow from the group count.
    localparam int CB_RUN    = 0;
    localparam int CB_IRQEN  = 1;
    localparam int CB_NOV_LO = 2;
endpackage

// File: rtl/nov_regs.sv
`timescale 1ns/1ps
// nov_regs: write-only configuration registers and the interrupt flag.
// Assumes CNT_W and 2+2*N_GRP do not exceed DATA_W. set_flag has priority
// over a clear written in the same cycle.
module nov_regs
    import nov_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PORT_W = 8,
    parameter int N_GRP  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_flag,
    output logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  margin,
    output logic [PORT_W-1:0] stage,
    output logic [PORT_W-1:0] dir,
    output logic [PORT_W-1:0] nde,
    output logic              run,
    output logic              irq_en,
    output logic [N_GRP-1:0]  nov_en,
    output logic [N_GRP-1:0]  trig_en,
    output logic              flag
);
    localparam int CTRL_W = 2 + 2 * N_GRP;

    logic [CTRL_W-1:0] ctrl_q;
    logic              clr_req;

    assign run     = ctrl_q[CB_RUN];
    assign irq_en  = ctrl_q[CB_IRQEN];
    assign nov_en  = ctrl_q[CB_NOV_LO +: N_GRP];
    assign trig_en = ctrl_q[CB_NOV_LO + N_GRP +: N_GRP];
    assign clr_req = wr_en && (wr_addr == RA_STATUS) && wr_data[0];

    // Purpose: capture configuration writes by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            margin <= '0;
            stage  <= '0;
            dir    <= '0;
            nde    <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_PERIOD: period <= wr_data[CNT_W-1:0];
                RA_MARGIN: margin <= wr_data[CNT_W-1:0];
                RA_STAGE:  stage  <= wr_data[PORT_W-1:0];
                RA_DIR:    dir    <= wr_data[PORT_W-1:0];
                RA_NDE:    nde    <= wr_data[PORT_W-1:0];
                RA_CTRL:   ctrl_q <= wr_data[CTRL_W-1:0];
                default:   ;
            endcase
        end
    end

    // Purpose: set the flag on an enabled margin event, clear on write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (set_flag) flag <= 1'b1;
        else if (clr_req)  flag <= 1'b0;
    end

    // R5: the flag only rises after a margin event that was enabled
    p_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set_flag));
    // R5: a write-one clear without a new event drops the flag
    p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_flag) |=> !flag);
endmodule

// File: rtl/nov_step_timer.sv
`timescale 1ns/1ps
// nov_step_timer: up-counter that clears on the period compare and flags
// the period and margin events. Assumes margin < period for a useful margin
// event; the period event wins if both compares match in the same cycle.
module nov_step_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] margin,
    output logic             match_b,
    output logic             match_a
);
    logic [CNT_W-1:0] cnt;

    assign match_b = run && (cnt == period);
    assign match_a = run && (cnt == margin);

    // Purpose: advance the counter while running and wrap on the period match.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (match_b) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end

    // R1: the counter is zero in the cycle after a period event
    p_clear_on_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        match_b |=> (cnt == '0));
    // R1: the counter holds while stopped
    p_hold_when_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));
    // R2: the margin event never fires while stopped
    p_margin_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !match_a);
endmodule

// File: rtl/nov_group.sv
`timescale 1ns/1ps
// nov_group: output register for one group of pulse bits. In non-overlap
// mode, falls happen at the period event and rises at the following margin
// event, using a pattern captured at the period event. In overlapping mode,
// the group copies the staged value at the period event.
// Assumes mask already combines direction, enable and trigger enable.
module nov_group #(
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          match_b,
    input  logic          match_a,
    input  logic          nov,
    input  logic [GW-1:0] mask,
    input  logic [GW-1:0] stage,
    output logic [GW-1:0] out
);
    logic [GW-1:0] pend_bits;
    logic [GW-1:0] pend_mask;
    logic          pend_v;

    // Purpose: apply falling/rising updates at their events and hold the
    // pending rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out       <= '0;
            pend_bits <= '0;
            pend_mask <= '0;
            pend_v    <= 1'b0;
        end else if (match_b) begin
            if (nov) begin
                out       <= out & ~(mask & ~stage);
                pend_bits <= stage;
                pend_mask <= mask;
                pend_v    <= 1'b1;
            end else begin
                out    <= (out & ~mask) | (stage & mask);
                pend_v <= 1'b0;
            end
        end else if (match_a && pend_v) begin
            out    <= out | (pend_bits & pend_mask);
            pend_v <= 1'b0;
        end
    end

    // R3: bits only fall at a period event
    p_fall_only_at_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !match_b |=> ((~out & $past(out)) == '0));
    // R4: in non-overlap mode bits only rise at a margin event
    p_rise_only_at_margin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nov && !match_a) |=> ((out & ~$past(out)) == '0));
    // R8: the captured rise pattern stays fixed until it is used
    p_pending_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v && !match_b) |=> ($stable(pend_bits) && $stable(pend_mask)));
    // R7: undriven bits keep their value
    p_masked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_b && (mask == '0)) |=> $stable(out));
endmodule

// File: rtl/nov_pulse_gen.sv
`timescale 1ns/1ps
// nov_pulse_gen: top of the non-overlapping pulse pattern generator.
// Connects the register bank, the step timer and one output group per
// GRP_W bits. Assumes PORT_W is a multiple of GRP_W.
module nov_pulse_gen
    import nov_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int GRP_W  = 4,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PORT_W-1:0] pulse_out,
    output logic              irq
);
    localparam int N_GRP = PORT_W / GRP_W;

    logic [CNT_W-1:0]  period, margin;
    logic [PORT_W-1:0] stage, dir, nde, drive;
    logic              run, irq_en, flag, match_a, match_b;
    logic [N_GRP-1:0]  nov_en, trig_en;

    assign irq = flag;

    nov_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PORT_W(PORT_W), .N_GRP(N_GRP)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .set_flag(match_a && irq_en),
        .period(period), .margin(margin), .stage(stage), .dir(dir), .nde(nde),
        .run(run), .irq_en(irq_en), .nov_en(nov_en), .trig_en(trig_en),
        .flag(flag)
    );

    nov_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .period(period), .margin(margin),
        .match_b(match_b), .match_a(match_a)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        // Purpose: a bit is driven only when direction, enable and trigger agree.
        assign drive[g*GRP_W +: GRP_W] = dir[g*GRP_W +: GRP_W]
                                       & nde[g*GRP_W +: GRP_W]
                                       & {GRP_W{trig_en[g]}};

        nov_group #(.GW(GRP_W)) u_grp (
            .clk(clk), .rst_n(rst_n), .match_b(match_b), .match_a(match_a),
            .nov(nov_en[g]), .mask(drive[g*GRP_W +: GRP_W]),
            .stage(stage[g*GRP_W +: GRP_W]),
            .out(pulse_out[g*GRP_W +: GRP_W])
        );
    end

    // R6: with no event the port holds its value
    p_port_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_a && !match_b) |=> $stable(pulse_out));
    // R5: irq never rises while interrupts are disabled
    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !$rose(irq));
endmodule

// File: tb/nov_pulse_gen_test.sv
`timescale 1ns/1ps
// Directed bench for nov_pulse_gen: one task per scenario.
module nov_pulse_gen_test;
    localparam int PER = 11;
    localparam int MAR = 3;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  pulse_out;
    logic        irq;
    int checks = 0, errors = 0, cyc = 0;
    int last_fall = -1;

    nov_pulse_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pulse_out(pulse_out), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Waits at negedges for pulse_out to leave prev; returns the cycle number.
    task automatic wait_change(input logic [7:0] prev, output int at);
        int n = 0;
        do begin @(negedge clk); n++; end while (pulse_out == prev && n < 400);
        at = cyc;
    endtask

    task automatic hold_check(input string req, input logic [7:0] v, input int n);
        logic ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pulse_out != v) ok = 1'b0;
        end
        chk(req, ok ? v : pulse_out, v);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R9 reset outputs", pulse_out, 0);
        chk("R9 reset irq", irq, 0);
    endtask

    // One non-overlap step from cur to nxt; optionally overwrite STAGE mid-step.
    task automatic nov_step(input logic [7:0] cur, input logic [7:0] nxt, input bit corrupt);
        int tf, tr;
        wr(3'd2, {8'h00, nxt});
        wr(3'd6, 16'h0001);
        @(negedge clk);
        chk("R5 irq cleared by write-one", irq, 0);
        wait_change(cur, tf);
        chk("R3/R10 falling step value", pulse_out, cur & nxt);
        if (last_fall >= 0) chk("R1 period event spacing", tf - last_fall, PER + 1);
        last_fall = tf;
        if (corrupt) wr(3'd2, 16'h0000);
        wait_change(cur & nxt, tr);
        chk("R4/R10 rising step value", pulse_out, nxt);
        chk("R2 rise lags fall by margin+1", tr - tf, MAR + 1);
        chk("R5 irq set at margin event", irq, 1);
        if (corrupt) chk("R8 mid-step stage write ignored", pulse_out, nxt);
    endtask

    task automatic t_sequence;
        int t;
        wr(3'd0, PER); wr(3'd1, MAR);
        wr(3'd3, 16'h00FF); wr(3'd4, 16'h00FF);
        wr(3'd2, 16'h0095);
        wr(3'd5, 16'h003F);
        wait_change(8'h00, t);
        chk("R4/R10 first rise to 0x95", pulse_out, 8'h95);
        chk("R5 irq after first margin event", irq, 1);
        wr(3'd6, 16'h0000);
        @(negedge clk);
        chk("R5 write-zero leaves flag", irq, 1);
        nov_step(8'h95, 8'h65, 1'b0);
        nov_step(8'h65, 8'h59, 1'b1);
        nov_step(8'h59, 8'h56, 1'b0);
        nov_step(8'h56, 8'h95, 1'b0);
    endtask

    task automatic t_normal_mode;
        int t;
        wr(3'd5, 16'h0033);
        wr(3'd2, 16'h00A5);
        wait_change(8'h95, t);
        chk("R6 overlapping mode single-step copy", pulse_out, 8'hA5);
        hold_check("R6 no second update in overlapping mode", 8'hA5, MAR + 2);
    endtask

    task automatic t_mixed_groups;
        int t;
        wr(3'd5, 16'h003B);
        wr(3'd2, 16'h005A);
        wait_change(8'hA5, t);
        chk("R6 mixed: low group copied, high group fell", pulse_out, 8'h0A);
        wait_change(8'h0A, t);
        chk("R6 mixed: high group rose at margin", pulse_out, 8'h5A);
    endtask

    task automatic t_masking;
        int t;
        wr(3'd5, 16'h003F);
        wr(3'd3, 16'h000F);
        wr(3'd2, 16'h00A5);
        wait_change(8'h5A, t);
        chk("R7 dir mask: only low group falls", pulse_out, 8'h50);
        wait_change(8'h50, t);
        chk("R7 dir mask: high group held", pulse_out, 8'h55);
        wr(3'd5, 16'h002F);
        wr(3'd3, 16'h00FF);
        wr(3'd2, 16'h0000);
        wait_change(8'h55, t);
        chk("R7 trigger enable off: low group held", pulse_out, 8'h05);
        hold_check("R7 low group held across a period", 8'h05, PER + 2);
        wr(3'd5, 16'h003F);
        wr(3'd4, 16'h00F0);
        wr(3'd2, 16'h00FF);
        wait_change(8'h05, t);
        chk("R7 nde mask: only high group rises", pulse_out, 8'hF5);
    endtask

    task automatic t_irq_disabled;
        logic seen = 1'b0;
        wr(3'd5, 16'h003D);
        wr(3'd6, 16'h0001);
        for (int i = 0; i < 2 * (PER + 1) + 2; i++) begin
            @(negedge clk);
            if (irq) seen = 1'b1;
        end
        chk("R5 no irq while disabled", seen, 0);
    endtask

    task automatic t_mid_reset;
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset during run clears outputs", pulse_out, 0);
        chk("R9 reset during run clears irq", irq, 0);
        wr(3'd5, 16'h003F);
        hold_check("R9 cleared stage and masks keep port low", 8'h00, PER + 4);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_sequence();
        t_normal_mode();
        t_mixed_groups();
        t_masking();
        t_irq_disabled();
        t_mid_reset();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end
endmodule